// File: doc/BRIEF.md
# Interruptible Refresh Scheduler for One DRAM Rank

This block sits in a memory controller and decides, for a single rank, whether a refresh or a read runs in each cycle. An external periodic tick marks each refresh interval and adds one to the count of owed refreshes. Because the tick comes from outside, the block works the same at the normal rate, at the doubled high-temperature rate, and in the finer-grained refresh modes. Only the tick period and the bundle size parameters change.

Whenever the rank is idle and at least one refresh is owed, a refresh bundle starts at once. The block does not wait for a predicted quiet period. A bundle is a fixed number of rows, and each row takes a fixed number of cycles.

A normal refresh yields to a pending read at the next row boundary. Refresh-enable is dropped and the read is granted. After the read completes, refresh-enable rises again and the paused bundle continues from the row where it stopped. When the owed count reaches its ceiling, the next bundle is a forced refresh. A forced refresh runs to completion and cannot be paused.

Top module: `refresh_pause_sched`

## Requirements
- R1: `owed_o` increments by one on each cycle in which `tick_i` is high and never exceeds MAX_OWED (8). A tick that arrives at the ceiling is dropped, unless a bundle completes in the same cycle.
- R2: With the rank idle, at least one refresh owed, fewer than MAX_OWED owed and no read pending, `ref_en_o` is high from the next cycle on.
- R3: After reset, `ref_en_o`, `rd_grant_o`, `forced_o`, `owed_o` and `row_prog_o` are all zero.
- R4: During a normal refresh, a pending read pauses the refresh only at a row boundary, meaning no row is partly done. At that edge `ref_en_o` falls and `rd_grant_o` rises in the same cycle.
- R5: `ref_en_o` and `rd_grant_o` are never high together. A grant stays high until the cycle after `rd_done_i` is seen. `rd_done_i` has no effect while no grant is out.
- R6: `row_prog_o` counts the rows of the current bundle already refreshed. It holds its value across a pause and returns to zero when the bundle ends.
- R7: When the rank is idle and `owed_o` equals MAX_OWED, a forced refresh starts: `ref_en_o` and `forced_o` are both high. Until that bundle ends, no read is granted, whatever `rd_pend_i` does.
- R8: A bundle ends after ROWS × ROW_CYC cycles of active refresh (defaults 4 × 3). In that cycle `owed_o` drops by one and the rank returns to idle.
- R9: One cycle after a read ends, refresh-enable is raised again if any refresh is owed and no other read is pending.
- R10: When the rank is idle with fewer than MAX_OWED refreshes owed, a pending read is granted before a refresh starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per refresh interval |
| rd_pend_i | input | 1 | A read is waiting for the rank |
| rd_done_i | input | 1 | The granted read has finished |
| ref_en_o | output | 1 | Refresh-enable to the rank; low pauses |
| rd_grant_o | output | 1 | The rank is handed to the read |
| forced_o | output | 1 | The running refresh is forced and cannot be paused |
| owed_o | output | $clog2(MAX_OWED+1) | Refreshes owed |
| row_prog_o | output | $clog2(ROWS+1) | Rows of the current bundle already done |

## Verification
A wrong owed count shows up at the ports in one of two ways. Refresh-enable may stay high after the last owed bundle, or it may stay low while work is still owed. The same error also moves the forced refresh earlier or later, and that shift becomes visible within one bundle time.

A row-progress value that is lost or reset across a pause makes the resumed bundle end early or late. That error appears in `row_prog_o` at once, and in `ref_en_o` when the bundle finishes.

A pause taken in the middle of a row shows up as a grant that comes too early. Because the bench compares every output against its own model on every clock, each of these faults is reported within the cycle in which it first reaches a port.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REF  = 2'd1,
    ST_FREF = 2'd2,
    ST_READ = 2'd3
  } rps_state_e;

  // Owed-count step: one up per tick, one down per finished bundle,
  // clamped to the ceiling.
  function automatic int unsigned owed_step(input int unsigned cur,
                                            input logic inc,
                                            input logic dec,
                                            input int unsigned cap);
    int unsigned v;
    v = cur + (inc ? 1 : 0);
    if (dec && v > 0) v = v - 1;
    if (v > cap) v = cap;
    return v;
  endfunction

  // A row ends on the last cycle of its timer while the engine runs.
  function automatic logic row_last(input int unsigned tmr,
                                    input int unsigned cyc);
    return tmr == cyc - 1;
  endfunction
endpackage

// File: rtl/rps_owed_ctr.sv
module rps_owed_ctr #(
  parameter int unsigned MAX_OWED = 8,
  parameter int unsigned OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          done_i,
  output logic [OW-1:0] owed_o,
  output logic          at_cap_o,
  output logic          any_o
);
  import rps_pkg::*;

  logic [OW-1:0] owed_q;
  logic [OW-1:0] owed_d;

  always_comb owed_d = OW'(owed_step(int'(owed_q), tick_i, done_i, MAX_OWED));

  always_ff @(posedge clk) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_d;
  end

  assign owed_o   = owed_q;
  assign at_cap_o = (owed_q == OW'(MAX_OWED));
  assign any_o    = (owed_q != '0);

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(MAX_OWED));
  a_r1_tick_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !done_i && !at_cap_o) |=> (owed_q == $past(owed_q) + 1'b1));
  a_r8_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !tick_i) |=> (owed_q == $past(owed_q) - 1'b1));
endmodule

// File: rtl/rps_row_engine.sv
module rps_row_engine #(
  parameter int unsigned ROWS    = 4,
  parameter int unsigned ROW_CYC = 3,
  parameter int unsigned RW      = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  output logic          at_bnd_o,
  output logic          bundle_done_o,
  output logic [RW-1:0] rows_o
);
  import rps_pkg::*;

  localparam int unsigned TW = (ROW_CYC > 1) ? $clog2(ROW_CYC) : 1;

  logic [TW-1:0] tmr_q;
  logic [RW-1:0] rows_q;
  logic          row_end;

  assign row_end       = run_i && row_last(int'(tmr_q), ROW_CYC);
  assign bundle_done_o = row_end && (rows_q == RW'(ROWS - 1));
  assign at_bnd_o      = (tmr_q == '0);
  assign rows_o        = rows_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      rows_q <= '0;
    end else if (run_i) begin
      if (row_end) begin
        tmr_q  <= '0;
        rows_q <= bundle_done_o ? '0 : rows_q + 1'b1;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  a_r6_hold_when_paused: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(rows_q));
  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rows_q < RW'(ROWS));
endmodule

// File: rtl/rps_fsm.sv
module rps_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_pend_i,
  input  logic rd_done_i,
  input  logic at_cap_i,
  input  logic any_owed_i,
  input  logic at_bnd_i,
  input  logic bundle_done_i,
  output logic run_o,
  output logic ref_en_o,
  output logic rd_grant_o,
  output logic forced_o
);
  import rps_pkg::*;

  rps_state_e st_q, st_d;
  logic       pause_now;

  assign pause_now = (st_q == ST_REF) && rd_pend_i && at_bnd_i;
  assign run_o     = ((st_q == ST_REF) && !pause_now) || (st_q == ST_FREF);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (at_cap_i)        st_d = ST_FREF;
        else if (rd_pend_i)  st_d = ST_READ;
        else if (any_owed_i) st_d = ST_REF;
      end
      ST_REF:  if (pause_now) st_d = ST_READ;
      ST_FREF: st_d = ST_FREF;
      ST_READ: if (rd_done_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (bundle_done_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign ref_en_o   = (st_q == ST_REF) || (st_q == ST_FREF);
  assign rd_grant_o = (st_q == ST_READ);
  assign forced_o   = (st_q == ST_FREF);

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_en_o && rd_grant_o));
  a_r4_pause_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ref_en_o) && rd_grant_o) |-> $past(at_bnd_i));
  a_r7_forced_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_o && !bundle_done_i) |=> (forced_o && !rd_grant_o));
  a_r5_grant_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant_o && !rd_done_i) |=> rd_grant_o);
endmodule

// File: rtl/refresh_pause_sched.sv
module refresh_pause_sched #(
  parameter int unsigned ROWS     = 4,
  parameter int unsigned ROW_CYC  = 3,
  parameter int unsigned MAX_OWED = 8,
  parameter int unsigned OW       = $clog2(MAX_OWED + 1),
  parameter int unsigned RW       = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rd_pend_i,
  input  logic          rd_done_i,
  output logic          ref_en_o,
  output logic          rd_grant_o,
  output logic          forced_o,
  output logic [OW-1:0] owed_o,
  output logic [RW-1:0] row_prog_o
);
  logic run_w;
  logic at_bnd_w;
  logic bundle_done_w;
  logic at_cap_w;
  logic any_owed_w;

  rps_owed_ctr #(.MAX_OWED(MAX_OWED), .OW(OW)) u_owed (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .done_i(bundle_done_w),
    .owed_o(owed_o), .at_cap_o(at_cap_w), .any_o(any_owed_w)
  );

  rps_row_engine #(.ROWS(ROWS), .ROW_CYC(ROW_CYC), .RW(RW)) u_rows (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .at_bnd_o(at_bnd_w),
    .bundle_done_o(bundle_done_w), .rows_o(row_prog_o)
  );

  rps_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rd_pend_i(rd_pend_i), .rd_done_i(rd_done_i),
    .at_cap_i(at_cap_w), .any_owed_i(any_owed_w), .at_bnd_i(at_bnd_w),
    .bundle_done_i(bundle_done_w), .run_o(run_w), .ref_en_o(ref_en_o),
    .rd_grant_o(rd_grant_o), .forced_o(forced_o)
  );

  a_r8_completion_idles: assert property (@(posedge clk) disable iff (!rst_n)
    bundle_done_w |=> (!ref_en_o && row_prog_o == '0));
endmodule

// File: tb/refresh_pause_sched_tb.sv
module refresh_pause_sched_tb;
  localparam int ROWS = 4, RC = 3, MAXO = 8;

  logic clk = 0, rst_n = 0, tick_i = 0, rd_pend_i = 0, rd_done_i = 0;
  logic ref_en_o, rd_grant_o, forced_o;
  logic [3:0] owed_o;
  logic [2:0] row_prog_o;

  int checks = 0, fails = 0;
  // reference model: mode 0 idle, 1 refreshing, 2 forced, 3 reading
  int mode = 0, owed = 0, rows = 0, phase = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  refresh_pause_sched u_dut (.*);

  always @(posedge clk) begin
    int nm; bit adv, fin;
    if (!rst_n) begin
      mode = 0; owed = 0; rows = 0; phase = 0;
    end else begin
      nm = mode; adv = 0; fin = 0;
      if (mode == 0) begin
        if (owed >= MAXO) nm = 2;
        else if (rd_pend_i) nm = 3;
        else if (owed != 0) nm = 1;
      end else if (mode == 1) begin
        if (rd_pend_i && phase == 0) nm = 3; else adv = 1;
      end else if (mode == 2) adv = 1;
      else if (rd_done_i) nm = 0;
      if (adv) begin
        phase++;
        if (phase == RC) begin
          phase = 0; rows++;
          if (rows == ROWS) begin rows = 0; fin = 1; nm = 0; end
        end
      end
      if (tick_i) owed++;
      if (fin) owed--;
      if (owed > MAXO) owed = MAXO;
      mode = nm;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 R4 R9 ref_en", ref_en_o, (mode == 1 || mode == 2));
    chk("R5 R10 rd_grant", rd_grant_o, (mode == 3));
    chk("R7 forced", forced_o, (mode == 2));
    chk("R1 R8 owed", owed_o, owed);
    chk("R6 row_prog", row_prog_o, rows);
    chk("R5 exclusive", ref_en_o && rd_grant_o, 0);
  endtask

  task automatic cyc(input logic t, input logic p, input logic d);
    @(negedge clk);
    compare();
    tick_i = t; rd_pend_i = p; rd_done_i = d;
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 reset", {ref_en_o, rd_grant_o, forced_o, owed_o, row_prog_o}, 0);
    rst_n = 1;
    cyc(1, 0, 0);
    repeat (15) cyc(0, 0, 0);
    cyc(1, 0, 0);
    repeat (5) cyc(0, 0, 0);
    repeat (4) cyc(0, 1, 0);
    cyc(0, 0, 1);
    repeat (15) cyc(0, 0, 0);
    cyc(0, 0, 1);
    repeat (3) cyc(0, 1, 0);
    for (int i = 0; i < 10; i++) begin cyc(1, 1, 0); cyc(0, 1, 0); end
    cyc(0, 0, 1);
    repeat (30) cyc(0, 1, 0);
    cyc(0, 0, 1);
    repeat (100) cyc(0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[3:0] == 0, lfsr[7:5] != 0, (mode == 3) && lfsr[9]);
    end
    cyc(0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule